// File: doc/BRIEF.md
# Short-Address DMA Channel Controller

This block is one DMA channel that moves a single unit, an 8-bit byte or a 16-bit word, for every transfer request it accepts. One side of the move is a fixed peripheral address. The other side is a memory address that the channel advances, holds or rewinds, depending on its mode. Software loads the configuration with a one-cycle write strobe. Requests then arrive on one input line, and each accepted request produces one bus read followed by one bus write on a simple single-cycle memory bus.

There are three modes. Sequential mode steps the memory address by the unit size after each transfer, upward or downward. Fixed-address mode keeps the memory address unchanged. In both of these modes the channel counts down a 16-bit transfer count; when the count runs out it pulses a done interrupt and disables itself. Repeat mode counts blocks of 1 to 256 transfers in the low byte of the count register. At the end of each block it restores both the start address and the block count from their shadow copies and keeps running. Several instances may sit side by side, each with its own request line.

The sequencer has four states:
- `ST_IDLE`: waits for a request. `ST_IDLE -> ST_READ` when the channel is enabled, a request is present (live or pending) and the address is aligned.
- `ST_READ`: performs the read. `ST_READ -> ST_WRITE` always.
- `ST_WRITE`: performs the write. `ST_WRITE -> ST_UPDATE` always.
- `ST_UPDATE`: steps the address and the count, reloads them, or finishes. `ST_UPDATE -> ST_IDLE` always.

A misaligned word request in `ST_IDLE` stays in `ST_IDLE` and sets the error flag.

Top module: `sadma_channel`

## Requirements
- R1: After reset the channel is disabled, `err_o` and `done_o` are 0, and neither `bus_rd` nor `bus_wr` is asserted.
- R2: Each accepted request gives exactly one cycle with `bus_rd`, followed in the next cycle by exactly one cycle with `bus_wr`. The write carries the data that was read: all 16 bits when `cfg_word`=1, or the low byte with the upper byte zero when `cfg_word`=0. `bus_word` equals the configured size.
- R3: In sequential mode (`cfg_mode`=2'b00, and also 2'b11) the memory address moves by 1 for bytes or 2 for words after each transfer. It moves upward when `cfg_dec`=0 and downward when `cfg_dec`=1.
- R4: In fixed-address mode (`cfg_mode`=2'b01) the memory address never changes between configuration writes.
- R5: In sequential and fixed-address modes a loaded count of 0 stands for 65,536 transfers. After one transfer the count reads 16'hFFFF and the channel stays enabled.
- R6: In sequential and fixed-address modes, the transfer that brings the count to zero raises `done_o` for exactly one cycle and clears `en_o`. After that, requests cause no bus access until the next configuration write.
- R7: In repeat mode (`cfg_mode`=2'b10) the low count byte (0 meaning 256) sets the block length. After the last transfer of a block, the memory address and the low count byte return to their loaded values. `done_o` is never raised and `en_o` stays 1.
- R8: A request that arrives while a transfer is in progress is held and serviced after the channel returns to `ST_IDLE`.
- R9: A word-size request with an odd memory address sets `err_o`, clears `en_o` and makes no bus access. A configuration write clears `err_o`.
- R10: When `cfg_to_mem`=1 the read uses the peripheral address and the write uses the memory address. When `cfg_to_mem`=0 the two are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle strobe that loads all configuration fields |
| cfg_en | input | 1 | Enable value to load |
| cfg_mode | input | 2 | 00 sequential, 01 fixed address, 10 repeat, 11 sequential |
| cfg_word | input | 1 | 1 = 16-bit unit, 0 = 8-bit unit |
| cfg_dec | input | 1 | 1 = step the memory address downward |
| cfg_to_mem | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| cfg_mem_addr | input | AW | Start memory address (also loaded into the shadow) |
| cfg_io_addr | input | AW | Fixed peripheral address |
| cfg_count | input | CW | Transfer count (low RW bits in repeat mode) |
| req_i | input | 1 | Transfer request |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_word | output | 1 | Access is 16-bit |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |
| done_o | output | 1 | Done interrupt pulse |
| err_o | output | 1 | Misaligned word request flag |
| en_o | output | 1 | Channel enabled |
| addr_o | output | AW | Current memory address |
| count_o | output | CW | Current transfer count |

## Verification
The assertions assume that software writes the configuration only while the channel is in `ST_IDLE`. They also assume that the bus completes every access in one cycle, so read data is valid in the same cycle as `bus_rd`. The bench issues every configuration write after the previous transfer has finished, and its bus model returns read data combinationally from a byte array that never changes. Requests are one-cycle pulses driven on the falling edge. The only ones sent during a transfer are the deliberate ones that test the pending-request path.

// File: rtl/sadma_pkg.sv
package sadma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_UPDATE = 2'd3
    } state_t;

    typedef enum logic [1:0] {
        MODE_SEQ   = 2'd0,
        MODE_FIXED = 2'd1,
        MODE_RPT   = 2'd2,
        MODE_SEQ2  = 2'd3
    } mode_t;
endpackage

// File: rtl/sadma_fsm.sv
module sadma_fsm
    import sadma_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    output state_t state,
    output logic   in_idle,
    output logic   do_rd,
    output logic   do_wr,
    output logic   do_upd
);
    state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        in_idle = 1'b0;
        do_rd   = 1'b0;
        do_wr   = 1'b0;
        do_upd  = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_idle = 1'b1;
            ST_READ:   do_rd   = 1'b1;
            ST_WRITE:  do_wr   = 1'b1;
            ST_UPDATE: do_upd  = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/sadma_addr.sv
module sadma_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          upd,
    input  logic          reload,
    input  logic          fixed,
    input  logic          word,
    input  logic          dec,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q, shadow_q, step, stepped;

    assign step    = word ? AW'(2) : AW'(1);
    assign stepped = dec ? (addr_q - step) : (addr_q + step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            shadow_q <= '0;
        end else if (load) begin
            addr_q   <= load_val;
            shadow_q <= load_val;
        end else if (upd) begin
            if (reload)      addr_q <= shadow_q;
            else if (!fixed) addr_q <= stepped;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/sadma_count.sv
module sadma_count #(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          upd,
    input  logic          rpt,
    output logic          last,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] shadow_q;

    // the transfer now under way is the last of the run or of the block
    assign last = rpt ? (cnt_q[RW-1:0] == RW'(1)) : (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else if (load) begin
            cnt_q    <= load_val;
            shadow_q <= load_val[RW-1:0];
        end else if (upd) begin
            if (rpt) begin
                if (last) cnt_q[RW-1:0] <= shadow_q;
                else      cnt_q[RW-1:0] <= cnt_q[RW-1:0] - RW'(1);
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
    import sadma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_word,
    input  logic          cfg_dec,
    input  logic          cfg_to_mem,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [AW-1:0] cfg_io_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          req_i,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    output logic          done_o,
    output logic          err_o,
    output logic          en_o,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] count_o
);
    localparam int DW = 16;

    mode_t         mode_q;
    logic          en_q, err_q, pend_q, word_q, dec_q, tomem_q;
    logic [AW-1:0] io_q, mem_addr;
    logic [DW-1:0] data_q;
    logic          in_idle, do_rd, do_wr, do_upd;
    logic          want, misalign, go, fault, last, done, is_rpt, is_fixed;
    state_t        state;

    assign is_rpt   = (mode_q == MODE_RPT);
    assign is_fixed = (mode_q == MODE_FIXED);
    assign want     = en_q && (pend_q || req_i);
    assign misalign = word_q && mem_addr[0];
    assign go       = in_idle && want && !misalign;
    assign fault    = in_idle && want && misalign;
    assign done     = do_upd && last && !is_rpt;

    sadma_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .state   (state),
        .in_idle (in_idle),
        .do_rd   (do_rd),
        .do_wr   (do_wr),
        .do_upd  (do_upd)
    );

    sadma_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (cfg_mem_addr),
        .upd      (do_upd),
        .reload   (is_rpt && last),
        .fixed    (is_fixed),
        .word     (word_q),
        .dec      (dec_q),
        .addr     (mem_addr)
    );

    sadma_count #(.CW(CW), .RW(RW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (cfg_count),
        .upd      (do_upd),
        .rpt      (is_rpt),
        .last     (last),
        .count    (count_o)
    );

    // configuration, enable, error and pending request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            pend_q  <= 1'b0;
            mode_q  <= MODE_SEQ;
            word_q  <= 1'b0;
            dec_q   <= 1'b0;
            tomem_q <= 1'b0;
            io_q    <= '0;
        end else if (cfg_wr) begin
            en_q    <= cfg_en;
            err_q   <= 1'b0;
            pend_q  <= 1'b0;
            mode_q  <= mode_t'(cfg_mode);
            word_q  <= cfg_word;
            dec_q   <= cfg_dec;
            tomem_q <= cfg_to_mem;
            io_q    <= cfg_io_addr;
        end else begin
            if (fault) begin
                en_q   <= 1'b0;
                err_q  <= 1'b1;
                pend_q <= 1'b0;
            end else if (done) begin
                en_q   <= 1'b0;
                pend_q <= 1'b0;
            end else if (go) begin
                pend_q <= 1'b0;
            end else if (req_i && en_q) begin
                pend_q <= 1'b1;
            end
        end
    end

    // read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     data_q <= '0;
        else if (do_rd) data_q <= word_q ? bus_rdata : {8'h00, bus_rdata[7:0]};
    end

    // bus drive
    always_comb begin
        bus_rd    = do_rd;
        bus_wr    = do_wr;
        bus_word  = word_q;
        bus_wdata = data_q;
        bus_addr  = '0;
        if (do_rd)      bus_addr = tomem_q ? io_q : mem_addr;
        else if (do_wr) bus_addr = tomem_q ? mem_addr : io_q;
    end

    assign done_o = done;
    assign err_o  = err_q;
    assign en_o   = en_q;
    assign addr_o = mem_addr;
endmodule

// File: rtl/sadma_channel_chk.sv
module sadma_channel_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_word,
    input logic          done_o,
    input logic          err_o,
    input logic          en_o,
    input logic [AW-1:0] addr_o,
    input logic [1:0]    mode_q
);
    // R2: a read is always followed by a write in the next cycle
    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    // R2: read and write never share a cycle
    p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R4: fixed-address mode holds the memory address
    p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && mode_q == 2'b01) |=> $stable(addr_o));

    // R6: the done pulse lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done disables the channel
    p_done_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cfg_wr) |=> !en_o);

    // R7: no done interrupt in repeat mode
    p_no_done_rpt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b10) |-> !done_o);

    // R9: word reads only start from an even memory address
    p_word_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_word) |-> !addr_o[0]);

    // R9: the error flag rises with no bus access following
    p_err_no_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!bus_rd && !en_o));
endmodule

bind sadma_channel sadma_channel_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .done_o   (done_o),
    .err_o    (err_o),
    .en_o     (en_o),
    .addr_o   (addr_o),
    .mode_q   (mode_q)
);

// File: tb/sadma_channel_tb.sv
module sadma_channel_tb;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_en = 1'b0, cfg_word = 1'b0, cfg_dec = 1'b0, cfg_to_mem = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [AW-1:0] cfg_mem_addr = '0, cfg_io_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          req_i = 1'b0;
    logic          bus_rd, bus_wr, bus_word, done_o, err_o, en_o;
    logic [AW-1:0] bus_addr, addr_o;
    logic [15:0]   bus_wdata, bus_rdata;
    logic [CW-1:0] count_o;

    logic [7:0] mem [0:255];
    int tests = 0, fails = 0;
    int wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
    logic [AW-1:0] last_wa;
    logic [15:0]   last_wd;

    always #2 clk = ~clk;

    sadma_channel #(.AW(AW), .CW(CW), .RW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_mode(cfg_mode), .cfg_word(cfg_word), .cfg_dec(cfg_dec),
        .cfg_to_mem(cfg_to_mem), .cfg_mem_addr(cfg_mem_addr),
        .cfg_io_addr(cfg_io_addr), .cfg_count(cfg_count), .req_i(req_i),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_o(done_o), .err_o(err_o), .en_o(en_o), .addr_o(addr_o),
        .count_o(count_o)
    );

    assign bus_rdata = {mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};

    always @(negedge clk) begin
        if (bus_wr) begin
            wr_cnt  <= wr_cnt + 1;
            last_wa <= bus_addr;
            last_wd <= bus_wdata;
        end
        if (bus_rd)  rd_cnt   <= rd_cnt + 1;
        if (done_o)  done_cnt <= done_cnt + 1;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] m, input logic w, input logic d, input logic t,
                             input logic [AW-1:0] ma, input logic [AW-1:0] ia, input logic [CW-1:0] n);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = 1'b1; cfg_mode = m; cfg_word = w; cfg_dec = d;
        cfg_to_mem = t; cfg_mem_addr = ma; cfg_io_addr = ia; cfg_count = n;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); req_i = 1'b1;
        @(negedge clk); req_i = 1'b0;
    endtask

    function automatic logic [15:0] rd_model(input logic [AW-1:0] a, input logic w);
        logic [7:0] lo, hi;
        lo = mem[a[7:0]];
        hi = mem[8'(a[7:0] + 8'd1)];
        return w ? {hi, lo} : {8'h00, lo};
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({31'b0, en_o}, 0, "R1 en");
        chk({31'b0, err_o}, 0, "R1 err");
        chk({30'b0, bus_rd, bus_wr}, 0, "R1 bus");
        chk({31'b0, done_o}, 0, "R1 done");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rd_cnt, 0, "R1 no read after reset");

        // sweep over mode, size, direction and transfer direction
        for (int m = 0; m < 3; m++)
        for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
        for (int t = 0; t < 2; t++) begin
            int n, xf, st, w0, d0;
            logic [AW-1:0] base, ioa, ma, exp_wa;
            logic [15:0] exp_wd;
            n = 3; xf = (m == 2) ? 7 : 3;
            st = (w == 1) ? 2 : 1;
            base = 16'h0040; ioa = 16'h0080;
            configure(2'(m), 1'(w), 1'(d), 1'(t), base, ioa, 16'(n));
            d0 = done_cnt;
            for (int k = 0; k < xf; k++) begin
                int kk;
                kk = (m == 1) ? 0 : ((m == 2) ? (k % n) : k);
                ma = (d == 1) ? base - 16'(kk * st) : base + 16'(kk * st);
                if (t == 1) begin exp_wa = ma;  exp_wd = rd_model(ioa, 1'(w)); end
                else        begin exp_wa = ioa; exp_wd = rd_model(ma, 1'(w)); end
                w0 = wr_cnt;
                pulse_req();
                repeat (4) @(negedge clk);
                chk(wr_cnt - w0, 1, "R2 one write per request");
                chk({16'b0, last_wa}, {16'b0, exp_wa}, (m == 1) ? "R4 fixed address" :
                    ((t == 1) ? "R10 to memory / R3 step" : "R10 from memory / R3 step"));
                chk({16'b0, last_wd}, {16'b0, exp_wd}, "R2 write data");
            end
            if (m == 2) begin
                chk(done_cnt - d0, 0, "R7 no done");
                chk({31'b0, en_o}, 1, "R7 stays enabled");
                ma = (d == 1) ? base - 16'(st) : base + 16'(st);
                chk({16'b0, addr_o}, {16'b0, ma}, "R7 address after reload");
                chk({24'b0, count_o[7:0]}, 2, "R7 count after reload");
                cfg_wr = 1'b0;
                configure(2'b00, 1'b0, 1'b0, 1'b0, 16'h0040, 16'h0080, 16'd1);
                @(negedge clk);
                cfg_en = 1'b0;
                @(negedge clk); cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
            end else begin
                chk(done_cnt - d0, 1, "R6 one done pulse");
                chk({31'b0, en_o}, 0, "R6 disabled");
                w0 = wr_cnt;
                pulse_req();
                repeat (5) @(negedge clk);
                chk(wr_cnt - w0, 0, "R6 request ignored");
            end
        end

        // R5: zero count means 65536
        begin
            int d0;
            d0 = done_cnt;
            configure(2'b00, 1'b0, 1'b0, 1'b1, 16'h0010, 16'h0080, 16'd0);
            pulse_req();
            repeat (4) @(negedge clk);
            chk({16'b0, count_o}, 32'h0000FFFF, "R5 count wraps");
            chk({31'b0, en_o}, 1, "R5 still enabled");
            chk(done_cnt - d0, 0, "R5 no done");
        end

        // R8: request during a transfer is held
        begin
            int w0;
            configure(2'b00, 1'b0, 1'b0, 1'b1, 16'h0020, 16'h0080, 16'd5);
            w0 = wr_cnt;
            @(negedge clk); req_i = 1'b1;
            @(negedge clk); req_i = 1'b1;
            @(negedge clk); req_i = 1'b0;
            repeat (10) @(negedge clk);
            chk(wr_cnt - w0, 2, "R8 pending serviced");
            chk({16'b0, addr_o}, 32'h22, "R8 address after two");
        end

        // R9: odd word address
        begin
            int w0, r0;
            configure(2'b00, 1'b1, 1'b0, 1'b1, 16'h0041, 16'h0080, 16'd4);
            w0 = wr_cnt; r0 = rd_cnt;
            pulse_req();
            repeat (5) @(negedge clk);
            chk({31'b0, err_o}, 1, "R9 error set");
            chk({31'b0, en_o}, 0, "R9 disabled");
            chk(rd_cnt - r0, 0, "R9 no read");
            chk(wr_cnt - w0, 0, "R9 no write");
            configure(2'b00, 1'b1, 1'b0, 1'b1, 16'h0042, 16'h0080, 16'd4);
            chk({31'b0, err_o}, 0, "R9 cleared by config");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule